// File: doc/BRIEF.md
# Crystal Reference and Time-Base Divider

This block turns a single crystal clock into the three timing signals a tuner synthesizer needs. The first is a reference tick whose rate is picked by a 3-bit code from the control register. The tick is one crystal cycle wide and feeds the phase comparator. The second is a free-running controller clock. The third is a slow square wave that serves as a time base. All divide ratios are worked out at elaboration from the crystal frequency parameter. Elaboration stops with an error if any rate does not divide the crystal evenly.

When the reference code changes, the reference counter starts again from zero. The comparator therefore never sees a shortened or merged reference period. The controller clock and the time base ignore the code completely and keep running.

Top module: `xtal_ref_timebase`

## Requirements
- R1: With a 7.2 MHz crystal, the reference code selects these tick periods in crystal cycles: 000 gives 72 (100 kHz), 001 gives 144 (50 kHz), 010 gives 288 (25 kHz), 011 gives 1440 (5 kHz), 100 gives 720 (10 kHz), 101 gives 800 (9 kHz), 110 gives 7200 (1 kHz) and 111 gives 1440 (5 kHz).
- R2: `ref_tick` is high for exactly one crystal cycle, and successive ticks are exactly one selected period apart while the code is held.
- R3: A code that differs from the one in use is taken at the next clock edge and restarts the count. No tick appears until exactly one full new period after that edge, whatever point the old period had reached.
- R4: Codes 011 and 111 give the same rate. Changing from one to the other still counts as a code change and restarts the count as R3 describes.
- R5: `ctrl_clk` is the crystal divided by XTAL_HZ/CTRL_HZ (18 by default, giving 400 kHz). It is high for half the period and low for the other half. Its first rising edge comes half a period after reset is released.
- R6: `time_base` is the crystal divided by XTAL_HZ/TB_HZ (900000 by default, giving 8 Hz). It has a 50% duty cycle and its first rising edge comes half a period after reset is released.
- R7: While `rst_n` is low, all three outputs are low and the code in use is 000. After release, the first tick comes exactly one 000-period after the release, provided the code is held at 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_code | input | 3 | Reference rate select code |
| ref_tick | output | 1 | One-cycle reference pulse |
| ctrl_clk | output | 1 | Controller clock, 50% duty |
| time_base | output | 1 | Slow time-base square wave, 50% duty |

## Verification
The hardest case to reach is a code change that lands partway through a long period. The old count must be thrown away rather than finished. The stimulus waits a fixed number of cycles after a tick, well short of the current period, and then writes a new code. It does this from 1 kHz to 100 kHz, and again between the two codes that share the 5 kHz rate. Each time, the monitor expects the next tick exactly one new period after the edge that took the code. The time base is built with a higher TB_HZ so that several of its periods fit into the run.

// File: rtl/xrt_pkg.sv
package xrt_pkg;

   typedef logic [2:0] ref_code_t;

   localparam int unsigned NUM_CODES = 8;

   // Reference rate in Hz for each select code; 011 and 111 share 5 kHz.
   function automatic int unsigned ref_hz(input ref_code_t code);
      case (code)
         3'b000:  return 100_000;
         3'b001:  return 50_000;
         3'b010:  return 25_000;
         3'b011:  return 5_000;
         3'b100:  return 10_000;
         3'b101:  return 9_000;
         3'b110:  return 1_000;
         default: return 5_000;
      endcase
   endfunction

   function automatic int unsigned min_ref_hz();
      int unsigned m;
      m = ref_hz(3'd0);
      for (int i = 1; i < NUM_CODES; i++) begin
         if (ref_hz(3'(i)) < m) m = ref_hz(3'(i));
      end
      return m;
   endfunction

endpackage

// File: rtl/xrt_sq_div.sv
module xrt_sq_div #(
   parameter int unsigned DIV = 18
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic sq_o
);
   localparam int unsigned HALF = DIV / 2;
   localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("xrt_sq_div: DIV must be even and at least 2");
   end

   logic [CW-1:0] cnt;
   logic          sq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt  <= '0;
         sq_q <= 1'b0;
      end else if (cnt == LAST) begin
         cnt  <= '0;
         sq_q <= ~sq_q;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

   assign sq_o = sq_q;

   AST_SQ_EDGE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sq_q) |-> (cnt == '0)); // R5 R6
   AST_SQ_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= LAST); // R5 R6

endmodule

// File: rtl/xrt_ref_counter.sv
module xrt_ref_counter
   import xrt_pkg::*;
#(
   parameter int unsigned XTAL_HZ = 7_200_000
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  ref_code_t code_i,
   output logic      tick_o
);
   localparam int unsigned MAX_DIV = XTAL_HZ / min_ref_hz();
   localparam int unsigned CW      = $clog2(MAX_DIV);

   logic [CW-1:0] lim_tab [NUM_CODES];

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
      localparam int unsigned RATE = ref_hz(3'(g));
      localparam int unsigned D    = XTAL_HZ / RATE;
      if (D * RATE != XTAL_HZ || D < 2) begin : g_bad_rate
         $error("xrt_ref_counter: crystal not an integer multiple of a reference rate");
      end
      assign lim_tab[g] = CW'(D - 1);
   end

   ref_code_t     code_q;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          tick_q;
   logic          code_chg;

   always_comb begin
      lim      = lim_tab[code_q];
      code_chg = (code_i != code_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
         cnt    <= '0;
         tick_q <= 1'b0;
      end else if (code_chg) begin
         code_q <= code_i;
         cnt    <= '0;
         tick_q <= 1'b0;
      end else if (cnt == lim) begin
         cnt    <= '0;
         tick_q <= 1'b1;
      end else begin
         cnt    <= cnt + 1'b1;
         tick_q <= 1'b0;
      end
   end

   assign tick_o = tick_q;

   AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_q |=> !tick_q); // R2
   AST_TICK_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tick_q) |-> ($past(cnt) == $past(lim))); // R2
   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= lim); // R1
   AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_i != code_q) |=> (cnt == '0 && !tick_q)); // R3

endmodule

// File: rtl/xtal_ref_timebase.sv
module xtal_ref_timebase #(
   parameter int unsigned XTAL_HZ = 7_200_000,
   parameter int unsigned CTRL_HZ = 400_000,
   parameter int unsigned TB_HZ   = 8
) (
   input  logic       clk_xtal,
   input  logic       rst_n,
   input  logic [2:0] ref_code,
   output logic       ref_tick,
   output logic       ctrl_clk,
   output logic       time_base
);
   localparam int unsigned CTRL_DIV = XTAL_HZ / CTRL_HZ;
   localparam int unsigned TB_DIV   = XTAL_HZ / TB_HZ;

   if (CTRL_DIV * CTRL_HZ != XTAL_HZ) begin : g_bad_ctrl
      $error("xtal_ref_timebase: controller rate does not divide crystal");
   end
   if (TB_DIV * TB_HZ != XTAL_HZ) begin : g_bad_tb
      $error("xtal_ref_timebase: time-base rate does not divide crystal");
   end

   xrt_ref_counter #(.XTAL_HZ(XTAL_HZ)) u_ref (
      .clk_i  (clk_xtal),
      .rst_ni (rst_n),
      .code_i (ref_code),
      .tick_o (ref_tick)
   );

   xrt_sq_div #(.DIV(CTRL_DIV)) u_ctrl (
      .clk_i  (clk_xtal),
      .rst_ni (rst_n),
      .sq_o   (ctrl_clk)
   );

   xrt_sq_div #(.DIV(TB_DIV)) u_tbase (
      .clk_i  (clk_xtal),
      .rst_ni (rst_n),
      .sq_o   (time_base)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_xtal)
      !rst_n |-> (!ref_tick && !ctrl_clk && !time_base)); // R7

endmodule

// File: tb/sim_xtal_ref_timebase.sv
module sim_xtal_ref_timebase;
   localparam int PER       = 10;
   localparam int TB_HZ_SIM = 36_000;   // 200-cycle time base
   localparam int CTRL_HALF = 9;
   localparam int TB_HALF   = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] code = 3'b000;
   logic       ref_tick, ctrl_clk, time_base;

   xtal_ref_timebase #(.XTAL_HZ(7_200_000), .CTRL_HZ(400_000), .TB_HZ(TB_HZ_SIM)) u0 (
      .clk_xtal (clk),
      .rst_n    (rst_n),
      .ref_code (code),
      .ref_tick (ref_tick),
      .ctrl_clk (ctrl_clk),
      .time_base(time_base)
   );

   always #(PER/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   int rel_cyc = -1;
   int exp_q[$];
   string tag_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_tb();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // Divide ratios from the requirement table, independent of the design.
   function automatic int div_of(input logic [2:0] c);
      case (c)
         3'b000: return 72;
         3'b001: return 144;
         3'b010: return 288;
         3'b011: return 1440;
         3'b100: return 720;
         3'b101: return 800;
         3'b110: return 7200;
         default: return 1440;
      endcase
   endfunction

   // Driver: wait, apply code, push expected tick cycles.
   task automatic run_code(input logic [2:0] c, input int n, input int pre, input string tag);
      int base;
      repeat (pre) @(negedge clk);
      code = c;
      base = cyc + 1;
      for (int i = 1; i <= n; i++) begin
         exp_q.push_back(base + i * div_of(c));
         tag_q.push_back(tag);
      end
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // Monitor: pop expected tick cycles and compare.
   always @(negedge clk) begin
      if (rst_n && ref_tick) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", cyc, -1, "tick with none expected");
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cyc == e, t, cyc, e, "tick cycle");
         end
      end
   end

   // Controller clock monitor (R5).
   logic c_prev = 1'b0;
   int   c_rise = -1, c_n = 0;
   always @(negedge clk) begin
      if (rst_n && rel_cyc >= 0) begin
         if (ctrl_clk && !c_prev) begin
            if (c_rise < 0) chk(cyc == rel_cyc + CTRL_HALF, "R5", cyc, rel_cyc + CTRL_HALF, "first ctrl rise");
            else if (c_n < 6) begin chk(cyc - c_rise == 2*CTRL_HALF, "R5", cyc - c_rise, 2*CTRL_HALF, "ctrl period"); c_n++; end
            c_rise = cyc;
         end
         if (!ctrl_clk && c_prev && c_n < 6)
            chk(cyc - c_rise == CTRL_HALF, "R5", cyc - c_rise, CTRL_HALF, "ctrl high time");
      end
      c_prev = ctrl_clk;
   end

   // Time-base monitor (R6).
   logic t_prev = 1'b0;
   int   t_rise = -1, t_n = 0;
   always @(negedge clk) begin
      if (rst_n && rel_cyc >= 0) begin
         if (time_base && !t_prev) begin
            if (t_rise < 0) chk(cyc == rel_cyc + TB_HALF, "R6", cyc, rel_cyc + TB_HALF, "first time-base rise");
            else if (t_n < 4) begin chk(cyc - t_rise == 2*TB_HALF, "R6", cyc - t_rise, 2*TB_HALF, "time-base period"); t_n++; end
            t_rise = cyc;
         end
         if (!time_base && t_prev && t_n < 4)
            chk(cyc - t_rise == TB_HALF, "R6", cyc - t_rise, TB_HALF, "time-base high time");
      end
      t_prev = time_base;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ref_tick == 1'b0, "R7", ref_tick, 0, "tick in reset");
      chk(ctrl_clk == 1'b0, "R7", ctrl_clk, 0, "ctrl in reset");
      chk(time_base == 1'b0, "R7", time_base, 0, "time base in reset");
      rst_n   = 1'b1;
      rel_cyc = cyc;
      for (int i = 1; i <= 3; i++) begin
         exp_q.push_back(rel_cyc + i * 72);
         tag_q.push_back("R7 R2");
      end
      while (exp_q.size() != 0) @(negedge clk);
      run_code(3'b001, 3, 0,   "R1 R3");
      run_code(3'b010, 2, 5,   "R1 R3");
      run_code(3'b100, 2, 100, "R1");
      run_code(3'b101, 2, 37,  "R1");
      run_code(3'b110, 2, 3,   "R1 R2");
      run_code(3'b000, 2, 1000, "R3");
      run_code(3'b011, 2, 0,   "R1");
      run_code(3'b111, 2, 500, "R4");
      run_code(3'b011, 1, 700, "R4");
      run_code(3'b000, 2, 20,  "R3");
      repeat (20) @(negedge clk);
      finish_tb();
   end

   initial begin
      #(PER * 200_000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_tb();
   end

endmodule